// File: doc/BRIEF.md
# Carrier and preamble presence detector

This block tells a host controller whether the power-line channel is busy. It reports on an active-low line `busy_n`. It takes a one-bit sliced copy of the received waveform, a demodulated data bit with a symbol strobe, and a lock flag from an external PLL. In carrier mode the line is reported busy when a tone close to the programmed carrier frequency is present. In preamble mode the tone must also carry at least four alternating symbols at the programmed symbol rate, and the PLL must be locked.

Tone presence is judged over a fixed window of `WIN` clocks by counting the rising edges of the sliced input. The carrier flag is set when that count lies between the programmable bounds `edge_min` and `edge_max`. The selected condition then passes through a digital filter, a four-state machine: IDLE (not detected), ARM (the condition is being confirmed), HOLD (detected) and RELEASE (the condition has gone and the loss is being confirmed). Its transitions are: IDLE→ARM when the condition appears; ARM→IDLE when it drops early; ARM→HOLD after T ticks; HOLD→RELEASE when it drops; RELEASE→HOLD when it returns; RELEASE→IDLE after T ticks. A restart from any state goes to IDLE. T is set by a 2-bit detection-time code, so a longer setting filters out more noise at the cost of a later report.

Top module: `cpd_top`

## Requirements
- R1: After reset `busy_n` is 1, and all counters, the carrier flag and the symbol run are zero. The first window closes on the WIN-th clock edge after reset is released.
- R2: A rising edge is a clock edge at which `rx_slice` is 1 and was 0 at the previous edge; the value before the first edge after reset counts as 0. Each window spans WIN edges. On its last edge the carrier flag becomes 1 if `edge_min` ≤ (edges counted in the window) ≤ `edge_max`, and 0 otherwise. The flag holds that value until the next window closes.
- R3: With `det_mode` = 0 (carrier mode), the condition fed to the filter is the carrier flag.
- R4: With `det_mode` = 1 (preamble mode), `rx_bit` is sampled on edges where `sym_stb` = 1. While the carrier flag is 1, a sampled symbol sets the run to 1 if the run is 0 or the symbol equals the previous sampled symbol. Otherwise it adds 1 to the run, which stops at 4. The condition is true when the run is 4, the carrier flag is 1 and `pll_lock` is 1.
- R5: While the carrier flag is 0 the run is held at 0. A low `pll_lock` removes the preamble condition in the same cycle.
- R6: The detection time T in clock ticks is CLK_HZ/2000 for code 0, CLK_HZ/1000 for code 1, 3·CLK_HZ/1000 for code 2 and 5·CLK_HZ/1000 for code 3. `busy_n` goes to 0 once the condition has been sampled true on T consecutive edges. A false sample before that returns the filter to IDLE.
- R7: Once `busy_n` is 0 it stays 0 until the condition has been sampled false on T consecutive edges. A true sample during that count keeps it at 0 and restarts the count.
- R8: On an edge where {`det_mode`, `det_time`} differs from its value at the previous edge, the filter goes to IDLE, and `busy_n` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_mode | input | 1 | 0 = carrier mode, 1 = preamble mode |
| det_time | input | 2 | Detection-time code |
| edge_min | input | EW | Lowest edge count per window accepted as carrier |
| edge_max | input | EW | Highest edge count per window accepted as carrier |
| rx_slice | input | 1 | Sliced receive signal |
| rx_bit | input | 1 | Demodulated data bit |
| sym_stb | input | 1 | One-cycle strobe marking a valid symbol in `rx_bit` |
| pll_lock | input | 1 | External PLL lock flag |
| busy_n | output | 1 | Active-low channel-busy indication |

## Verification
The carrier flag changes only on the last edge of a window, and the symbol run changes on the edge that samples a strobe. `busy_n` follows from the filter state one edge after the condition sample that moves it, so it falls exactly T edges after the first true sample of the condition. A restart shows up as `busy_n` = 1 after the edge that sees the new configuration. The bench drives all inputs on falling clock edges. It keeps a cycle-accurate model of the window, run and filter timing, derived from the requirements, and updates the model on rising edges. It compares `busy_n` with the model on every falling edge, so every result is checked in the cycle it is due and never in a later one. The sweep covers both modes, all four detection-time codes, tones with too many, too few and an acceptable number of edges, lock loss, broken alternation, and a tone that drops out and returns during release.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef enum logic [1:0] {
        FLT_IDLE    = 2'd0,
        FLT_ARM     = 2'd1,
        FLT_HOLD    = 2'd2,
        FLT_RELEASE = 2'd3
    } flt_state_e;

    typedef enum logic {
        DET_CARRIER  = 1'b0,
        DET_PREAMBLE = 1'b1
    } det_mode_e;

endpackage

// File: rtl/cpd_edge_meter.sv
module cpd_edge_meter #(
    parameter int unsigned WIN = 64,
    localparam int unsigned WW = (WIN > 1) ? $clog2(WIN) : 1,
    localparam int unsigned EW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_slice,
    input  logic [EW-1:0] edge_min,
    input  logic [EW-1:0] edge_max,
    output logic          carrier_ok
);

    logic          prev_q;
    logic [WW-1:0] win_cnt;
    logic [EW-1:0] edges;
    logic          rise;
    logic [EW-1:0] total;
    logic          win_last;

    always_comb begin
        rise     = rx_slice & ~prev_q;
        total    = edges + EW'(rise);
        win_last = (win_cnt == WW'(WIN - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            win_cnt    <= '0;
            edges      <= '0;
            carrier_ok <= 1'b0;
        end else begin
            prev_q <= rx_slice;
            if (win_last) begin
                win_cnt    <= '0;
                edges      <= '0;
                carrier_ok <= (total >= edge_min) && (total <= edge_max);
            end else begin
                win_cnt <= win_cnt + WW'(1);
                edges   <= total;
            end
        end
    end

    assert_edges_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edges <= EW'(WIN));

    assert_flag_only_at_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt != '0) |-> $stable(carrier_ok));

endmodule

// File: rtl/cpd_preamble_chk.sv
module cpd_preamble_chk #(
    parameter int unsigned PRE_LEN = 4,
    localparam int unsigned RW = $clog2(PRE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carrier_ok,
    input  logic pll_lock,
    input  logic rx_bit,
    input  logic sym_stb,
    output logic pre_ok
);

    logic [RW-1:0] run;
    logic          last_q;
    logic          repeat_sym;

    always_comb begin
        repeat_sym = (run == '0) || (rx_bit == last_q);
        pre_ok     = (run == RW'(PRE_LEN)) && carrier_ok && pll_lock;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= '0;
            last_q <= 1'b0;
        end else begin
            if (sym_stb) begin
                last_q <= rx_bit;
            end
            if (!carrier_ok) begin
                run <= '0;
            end else if (sym_stb) begin
                if (repeat_sym) begin
                    run <= RW'(1);
                end else if (run < RW'(PRE_LEN)) begin
                    run <= run + RW'(1);
                end
            end
        end
    end

    assert_run_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RW'(PRE_LEN));

    assert_repeat_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_ok && sym_stb && run != '0 && rx_bit == last_q) |=> (run == RW'(1)));

    assert_loss_clears_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |=> (run == '0));

endmodule

// File: rtl/cpd_filter.sv
module cpd_filter
    import cpd_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    localparam int unsigned T_Q = (CLK_HZ / 2000 > 0) ? CLK_HZ / 2000 : 1,
    localparam int unsigned T_1 = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1,
    localparam int unsigned T_3 = (3 * CLK_HZ / 1000 > 0) ? 3 * CLK_HZ / 1000 : 1,
    localparam int unsigned T_5 = (5 * CLK_HZ / 1000 > 0) ? 5 * CLK_HZ / 1000 : 1,
    localparam int unsigned TW  = $clog2(T_5 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cond,
    input  logic [1:0] code,
    input  logic       restart,
    output logic       busy_n
);

    flt_state_e    state, nxt;
    logic [TW-1:0] cnt, cnt_nxt;
    logic [TW-1:0] tsel;
    logic          single;
    logic          done;

    always_comb begin
        unique case (code)
            2'd0: tsel = TW'(T_Q);
            2'd1: tsel = TW'(T_1);
            2'd2: tsel = TW'(T_3);
            2'd3: tsel = TW'(T_5);
        endcase
        single = (tsel == TW'(1));
        done   = (cnt >= tsel - TW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FLT_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (restart) begin
            nxt     = FLT_IDLE;
            cnt_nxt = '0;
        end else begin
            unique case (state)
                FLT_IDLE: begin
                    if (cond) begin
                        nxt     = single ? FLT_HOLD : FLT_ARM;
                        cnt_nxt = single ? '0 : TW'(1);
                    end
                end
                FLT_ARM: begin
                    if (!cond) begin
                        nxt     = FLT_IDLE;
                        cnt_nxt = '0;
                    end else if (done) begin
                        nxt     = FLT_HOLD;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + TW'(1);
                    end
                end
                FLT_HOLD: begin
                    if (!cond) begin
                        nxt     = single ? FLT_IDLE : FLT_RELEASE;
                        cnt_nxt = single ? '0 : TW'(1);
                    end
                end
                FLT_RELEASE: begin
                    if (cond) begin
                        nxt     = FLT_HOLD;
                        cnt_nxt = '0;
                    end else if (done) begin
                        nxt     = FLT_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + TW'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            FLT_IDLE, FLT_ARM:    busy_n = 1'b1;
            FLT_HOLD, FLT_RELEASE: busy_n = 1'b0;
        endcase
    end

    assert_low_needs_cond_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_n) |-> $past(cond));

    assert_high_needs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> ($past(!cond) || $past(restart)));

    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n || restart)
        cnt < tsel);

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> busy_n);

endmodule

// File: rtl/cpd_top.sv
module cpd_top
    import cpd_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned WIN     = 64,
    parameter int unsigned PRE_LEN = 4,
    localparam int unsigned EW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          det_mode,
    input  logic [1:0]    det_time,
    input  logic [EW-1:0] edge_min,
    input  logic [EW-1:0] edge_max,
    input  logic          rx_slice,
    input  logic          rx_bit,
    input  logic          sym_stb,
    input  logic          pll_lock,
    output logic          busy_n
);

    logic       carrier_ok;
    logic       pre_ok;
    logic       cond;
    logic [2:0] cfg_q;
    logic       restart;

    cpd_edge_meter #(.WIN(WIN)) u_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_slice   (rx_slice),
        .edge_min   (edge_min),
        .edge_max   (edge_max),
        .carrier_ok (carrier_ok)
    );

    cpd_preamble_chk #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_ok (carrier_ok),
        .pll_lock   (pll_lock),
        .rx_bit     (rx_bit),
        .sym_stb    (sym_stb),
        .pre_ok     (pre_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= {det_mode, det_time};
        end
    end

    always_comb begin
        restart = ({det_mode, det_time} != cfg_q);
        unique case (det_mode_e'(det_mode))
            DET_CARRIER:  cond = carrier_ok;
            DET_PREAMBLE: cond = pre_ok;
        endcase
    end

    cpd_filter #(.CLK_HZ(CLK_HZ)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond    (cond),
        .code    (det_time),
        .restart (restart),
        .busy_n  (busy_n)
    );

endmodule

// File: tb/test_cpd_top.sv
module test_cpd_top;

    localparam int unsigned CLK_HZ = 8000;
    localparam int unsigned WIN    = 16;
    localparam int unsigned EW     = $clog2(WIN + 1);
    localparam int          SYMP   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          det_mode = 1'b0;
    logic [1:0]    det_time = 2'd0;
    logic [EW-1:0] edge_min = EW'(2);
    logic [EW-1:0] edge_max = EW'(5);
    logic          rx_slice = 1'b0;
    logic          rx_bit = 1'b0;
    logic          sym_stb = 1'b0;
    logic          pll_lock = 1'b0;
    logic          busy_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int ph = 0;
    int sc = 0;
    int sk = 0;

    always #5 clk = ~clk;

    cpd_top #(.CLK_HZ(CLK_HZ), .WIN(WIN), .PRE_LEN(4)) i_cpd_top (
        .clk(clk), .rst_n(rst_n), .det_mode(det_mode), .det_time(det_time),
        .edge_min(edge_min), .edge_max(edge_max), .rx_slice(rx_slice),
        .rx_bit(rx_bit), .sym_stb(sym_stb), .pll_lock(pll_lock), .busy_n(busy_n)
    );

    function automatic int ticks(input logic [1:0] c);
        case (c)
            2'd0:    return CLK_HZ * 1 / 2000;
            2'd1:    return CLK_HZ * 2 / 2000;
            2'd2:    return CLK_HZ * 6 / 2000;
            default: return CLK_HZ * 10 / 2000;
        endcase
    endfunction

    // Requirement model, updated on rising edges from the inputs set on falling edges
    logic m_prev, m_car, m_last;
    int   m_win, m_edges, m_run, m_state, m_cnt;
    logic [2:0] m_cfg;

    always @(posedge clk) begin
        int t, tot, ns, nc;
        logic cnd, rs, rise;
        if (!rst_n) begin
            m_prev <= 1'b0; m_car <= 1'b0; m_last <= 1'b0;
            m_win <= 0; m_edges <= 0; m_run <= 0; m_state <= 0; m_cnt <= 0;
            m_cfg <= 3'd0;
        end else begin
            t   = ticks(det_time);
            cnd = det_mode ? (m_run == 4 && m_car && pll_lock) : m_car;
            rs  = ({det_mode, det_time} != m_cfg);
            m_cfg <= {det_mode, det_time};
            ns = m_state; nc = m_cnt;
            if (rs) begin ns = 0; nc = 0; end
            else case (m_state)
                0: if (cnd) begin ns = (t == 1) ? 2 : 1; nc = (t == 1) ? 0 : 1; end
                1: if (!cnd) begin ns = 0; nc = 0; end
                   else if (m_cnt >= t - 1) begin ns = 2; nc = 0; end
                   else nc = m_cnt + 1;
                2: if (!cnd) begin ns = (t == 1) ? 0 : 3; nc = (t == 1) ? 0 : 1; end
                default: if (cnd) begin ns = 2; nc = 0; end
                   else if (m_cnt >= t - 1) begin ns = 0; nc = 0; end
                   else nc = m_cnt + 1;
            endcase
            m_state <= ns; m_cnt <= nc;
            rise = rx_slice && !m_prev;
            m_prev <= rx_slice;
            tot = m_edges + int'(rise);
            if (m_win == WIN - 1) begin
                m_win <= 0; m_edges <= 0;
                m_car <= (tot >= int'(edge_min)) && (tot <= int'(edge_max));
            end else begin
                m_win <= m_win + 1; m_edges <= tot;
            end
            if (sym_stb) m_last <= rx_bit;
            if (!m_car) m_run <= 0;
            else if (sym_stb) begin
                if (m_run == 0 || rx_bit == m_last) m_run <= 1;
                else if (m_run < 4) m_run <= m_run + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s busy_n actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // pat: 0 alternating, 1 alternation broken every third symbol
    task automatic run_phase(input int n, input int half, input int pat,
                             input bit lock, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, int'(busy_n), (m_state >= 2) ? 0 : 1);
            ph++;
            rx_slice = (half == 0) ? 1'b0 : (((ph / half) % 2) == 1);
            pll_lock = lock;
            sc++;
            if (sc % SYMP == 0) begin
                sk++;
                sym_stb = 1'b1;
                if (pat == 0 || (sk % 3) != 0) rx_bit = ~rx_bit;
            end else begin
                sym_stb = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", int'(busy_n), 1);
        rst_n = 1'b1;
        run_phase(WIN + 2, 0, 0, 1'b1, "R1");
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                string rq;
                @(negedge clk);
                det_mode = m[0];
                det_time = c[1:0];
                @(negedge clk);
                check("R8", int'(busy_n), 1);
                rq = (m == 0) ? "R3/R6" : "R4/R6";
                run_phase(200, 2, 0, 1'b1, rq);
                run_phase(150, 0, 0, 1'b1, "R7");
                run_phase(100, 1, 0, 1'b1, "R2");
                run_phase(100, 8, 0, 1'b1, "R2");
                run_phase(120, 3, 0, 1'b1, "R2");
                run_phase(100, 2, 0, 1'b1, "R5");
                run_phase(60, 2, 0, 1'b0, "R5");
                run_phase(100, 2, 0, 1'b1, "R5");
                run_phase(200, 2, 1, 1'b1, "R4");
                for (int k = 0; k < 5; k++) begin
                    run_phase(32, 2, 0, 1'b1, "R7");
                    run_phase(16, 0, 0, 1'b1, "R7");
                end
                run_phase(150, 2, 0, 1'b1, "R8");
            end
        end
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

endmodule